// File: doc/BRIEF.md
# Configuration Control Sequencer

This controller steps a programmable device from power-up or a program request through memory clearing, sampling of the mode pins, the load of a configuration stream, and a startup sequence that ends in user mode. It does not parse the stream and does no CRC arithmetic. It only reacts to four status flags from a separate stream parser: sync found, ID accepted, CRC error and load complete.

The INIT line is open-drain. The block drives it low through `init_drive_low` and reads the wired level back on `init_in`. An external agent can therefore stretch the clearing phase by holding the line low. A CRC error pulls the line low again and parks the controller in an error state. The startup events (DONE release, I/O enable, global write enable) occur one per cycle. Their order is set by a parameter.

Mode encoding of `mode`: 00 active SPI flash, 01 active parallel flash, 10 active serial, 11 passive.

Top module: `cfg_seq`

## Requirements
- R1: While `power_good` is 0, or once `prog_n` has been sampled low on GLITCH_MIN (default 4) consecutive rising edges, the block is in reset. In reset: `init_drive_low`=1, `io_hiz`=1, `done_rel`=0, `gwe`=0, `cclk_en`=0, `cfg_mode`=0, `cfg_variant`=0.
- R2: A `prog_n` low pulse seen on fewer than GLITCH_MIN consecutive edges has no effect on any output.
- R3: When the reset condition is removed, the block spends one more cycle in reset. After that, `mem_clear` and `init_drive_low` are both 1 for exactly CLEAR_CYCLES (default 8) cycles, with `io_hiz`=1.
- R4: After clearing, `init_drive_low` and `mem_clear` are 0. The block waits, with all mode outputs unchanged, for as long as `init_in` is 0.
- R5: On the first edge where `init_in` is 1 after clearing, `mode` is latched into `cfg_mode`. `variant` is latched into `cfg_variant` only when mode bit 1 is 0 (an SPI or parallel-flash mode); otherwise `cfg_variant` is 0.
- R6: From the latch edge until startup completes, `cclk_en` is 1 when `cfg_mode` is not 11. In passive mode (11) it stays 0.
- R7: Loading starts only after `sync_found` and then `id_ok`. A flag that arrives ahead of its turn (for example `load_done` before `id_ok`) is ignored.
- R8: `crc_err` during loading moves the block to an error state. There `init_drive_low`=1 and no startup event occurs, whatever other flags do, until a new reset condition.
- R9: After `load_done` during loading, the startup events fire on the next three edges, one each, in STARTUP_ORDER. The default order is DONE release (`done_rel`=1), then I/O enable (`io_hiz`=0), then `gwe`=1. After that `cclk_en` is 0.
- R10: Changes on `mode` and `variant` after the latch edge have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| power_good | input | 1 | Supply within range |
| prog_n | input | 1 | Active-low program request |
| init_in | input | 1 | Sampled level of the wired INIT line |
| mode | input | 2 | Mode-select pins |
| variant | input | 1 | Variant-select pin |
| sync_found | input | 1 | Parser found the sync word |
| id_ok | input | 1 | Parser accepted the device ID |
| crc_err | input | 1 | Parser reports a frame CRC failure |
| load_done | input | 1 | Parser finished loading |
| init_drive_low | output | 1 | Pull INIT low (open-drain enable) |
| mem_clear | output | 1 | Configuration memory clear strobe |
| cclk_en | output | 1 | Configuration clock enable (active modes) |
| io_hiz | output | 1 | User I/O tri-state |
| done_rel | output | 1 | DONE released |
| gwe | output | 1 | Global write enable |
| cfg_mode | output | 2 | Latched mode |
| cfg_variant | output | 1 | Latched variant (0 unless SPI or parallel flash) |

## Verification
Every output is registered state, or decoded from the state register, so each response is due on the first rising edge that samples the stimulus. The one exception is the program filter, which acts on the GLITCH_MIN-th consecutive low sample. The bench drives inputs just after a rising edge. A behavioural model, advanced on the same edge, predicts every output, and the two are compared at the falling edge of every cycle. Point checks at named moments cover the glitch filter, the INIT hold, out-of-order flags and the sticky error state.

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int GLITCH_MIN = 4,
  parameter int CLEAR_CYCLES = 8,
  parameter logic [5:0] STARTUP_ORDER = 6'b10_01_00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       power_good,
  input  logic       prog_n,
  input  logic       init_in,
  input  logic [1:0] mode,
  input  logic       variant,
  input  logic       sync_found,
  input  logic       id_ok,
  input  logic       crc_err,
  input  logic       load_done,
  output logic       init_drive_low,
  output logic       mem_clear,
  output logic       cclk_en,
  output logic       io_hiz,
  output logic       done_rel,
  output logic       gwe,
  output logic [1:0] cfg_mode,
  output logic       cfg_variant
);
  localparam int GW = (GLITCH_MIN > 2) ? $clog2(GLITCH_MIN) : 1;
  localparam int CW = (CLEAR_CYCLES > 2) ? $clog2(CLEAR_CYCLES) : 1;

  typedef enum logic [3:0] {
    S_RST, S_CLR, S_HOLD, S_SYNC, S_IDC, S_LOAD, S_START, S_USER, S_ERR
  } st_t;

  st_t st;
  logic [GW-1:0] pcnt;
  logic [CW-1:0] ccnt;
  logic [1:0] step;
  logic [2:0] ev;
  logic [1:0] code;
  logic reset_req;

  assign reset_req = !power_good || (!prog_n && pcnt == GW'(GLITCH_MIN - 1));
  assign code = STARTUP_ORDER[{step, 1'b0} +: 2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else if (prog_n) pcnt <= '0;
    else if (pcnt != GW'(GLITCH_MIN - 1)) pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RST;
      ccnt <= '0;
      step <= '0;
      ev <= '0;
      cfg_mode <= '0;
      cfg_variant <= 1'b0;
    end else if (reset_req) begin
      st <= S_RST;
      step <= '0;
      ev <= '0;
      cfg_mode <= '0;
      cfg_variant <= 1'b0;
    end else begin
      case (st)
        S_RST: begin
          st <= S_CLR;
          ccnt <= CW'(CLEAR_CYCLES - 1);
        end
        S_CLR: if (ccnt == '0) st <= S_HOLD; else ccnt <= ccnt - 1'b1;
        S_HOLD: if (init_in) begin
          st <= S_SYNC;
          cfg_mode <= mode;
          cfg_variant <= variant & ~mode[1];
        end
        S_SYNC: if (sync_found) st <= S_IDC;
        S_IDC: if (id_ok) st <= S_LOAD;
        S_LOAD: if (crc_err) st <= S_ERR;
                else if (load_done) begin st <= S_START; step <= '0; end
        S_START: begin
          ev <= ev | (3'b001 << code);
          step <= step + 1'b1;
          if (step == 2'd2) st <= S_USER;
        end
        default: ;
      endcase
    end
  end

  assign init_drive_low = (st == S_RST) || (st == S_CLR) || (st == S_ERR);
  assign mem_clear = (st == S_CLR);
  assign cclk_en = (st == S_SYNC || st == S_IDC || st == S_LOAD || st == S_START)
                   && cfg_mode != 2'b11;
  assign done_rel = ev[0];
  assign io_hiz = ~ev[1];
  assign gwe = ev[2];
endmodule

module cfg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       power_good,
  input logic       prog_n,
  input logic       init_drive_low,
  input logic       mem_clear,
  input logic       cclk_en,
  input logic       io_hiz,
  input logic       done_rel,
  input logic       gwe,
  input logic [1:0] cfg_mode,
  input logic [3:0] st
);
  p_clear_drives_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear |-> init_drive_low);
  p_power_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |=> (init_drive_low && io_hiz && !done_rel && !gwe && !cclk_en));
  p_one_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({$rose(done_rel), $fell(io_hiz), $rose(gwe)}) <= 1);
  p_no_clk_in_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear |-> !cclk_en);
  p_error_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd8 && power_good && prog_n) |=> (st == 4'd8 && init_drive_low));
  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd5 && $past(st) == 4'd5) |-> $stable(cfg_mode));
endmodule

bind cfg_seq cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .power_good(power_good), .prog_n(prog_n),
  .init_drive_low(init_drive_low), .mem_clear(mem_clear), .cclk_en(cclk_en),
  .io_hiz(io_hiz), .done_rel(done_rel), .gwe(gwe), .cfg_mode(cfg_mode), .st(st)
);

// File: tb/cfg_seq_test.sv
module cfg_seq_test;
  localparam int G = 4;
  localparam int NCLR = 8;

  logic clk = 0, rst_n = 0;
  logic power_good = 0, prog_n = 1, init_in = 0, variant = 0;
  logic sync_found = 0, id_ok = 0, crc_err = 0, load_done = 0;
  logic [1:0] mode = 0;
  logic init_drive_low, mem_clear, cclk_en, io_hiz, done_rel, gwe, cfg_variant;
  logic [1:0] cfg_mode;

  int vectors = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  cfg_seq uut (.*);

  int ph, plow, ccnt, step, m_done, m_io, m_gwe, m_mode, m_var;
  int ord[3] = '{0, 1, 2};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; plow = 0; ccnt = 0; step = 0;
      m_done = 0; m_io = 0; m_gwe = 0; m_mode = 0; m_var = 0;
    end else begin
      bit req;
      req = !power_good || (!prog_n && plow >= G - 1);
      plow = prog_n ? 0 : (plow < G - 1 ? plow + 1 : plow);
      if (req) begin
        ph = 0; step = 0; m_done = 0; m_io = 0; m_gwe = 0; m_mode = 0; m_var = 0;
      end else if (ph == 0) begin ph = 1; ccnt = NCLR; end
      else if (ph == 1) begin ccnt--; if (ccnt == 0) ph = 2; end
      else if (ph == 2) begin
        if (init_in) begin
          ph = 3; m_mode = mode; m_var = (mode < 2) ? variant : 0;
        end
      end
      else if (ph == 3) begin if (sync_found) ph = 4; end
      else if (ph == 4) begin if (id_ok) ph = 5; end
      else if (ph == 5) begin
        if (crc_err) ph = 8; else if (load_done) begin ph = 6; step = 0; end
      end
      else if (ph == 6) begin
        case (ord[step]) 0: m_done = 1; 1: m_io = 1; default: m_gwe = 1; endcase
        step++;
        if (step == 3) ph = 7;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(init_drive_low, (ph == 0 || ph == 1 || ph == 8), "R3 init_drive_low");
    chk(mem_clear, ph == 1, "R3 mem_clear");
    chk(cclk_en, (ph >= 3 && ph <= 6 && m_mode != 3), "R6 cclk_en");
    chk(io_hiz, !m_io, "R9 io_hiz");
    chk(done_rel, m_done, "R9 done_rel");
    chk(gwe, m_gwe, "R9 gwe");
    chk(cfg_mode, m_mode, "R5 cfg_mode");
    chk(cfg_variant, m_var, "R5 cfg_variant");
  end

  task automatic step_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pt(input int act, input int exp, input string tag);
    @(negedge clk);
    chk(act, exp, tag);
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic bring_up(input logic [1:0] m, input logic v, input int hold);
    init_in = 0; mode = m; variant = v;
    step_n(1 + NCLR);
    step_n(hold);
    init_in = 1;
    step_n(1);
  endtask

  initial begin
    step_n(2); rst_n = 1;
    step_n(3);
    pt(init_drive_low & io_hiz & !done_rel, 1, "R1 reset outputs while power low");
    power_good = 1;
    bring_up(2'b00, 1'b1, 5);
    pt(init_drive_low, 0, "R4 init released during hold");
    load_done = 1; step_n(2); load_done = 0;
    sync_found = 1; step_n(1); sync_found = 0;
    load_done = 1; step_n(2); load_done = 0;
    pt(done_rel, 0, "R7 early load_done ignored");
    id_ok = 1; step_n(1); id_ok = 0;
    mode = 2'b11; variant = 0;
    step_n(3);
    pt(cfg_mode, 0, "R10 mode pins ignored after latch");
    load_done = 1; step_n(1); load_done = 0;
    step_n(5);
    pt(gwe & done_rel & !io_hiz, 1, "R9 user mode reached");
    prog_n = 0; step_n(G - 1); prog_n = 1;
    step_n(2);
    pt(gwe, 1, "R2 short program pulse ignored");
    prog_n = 0; step_n(G + 2); prog_n = 1;
    bring_up(2'b10, 1'b1, 0);
    sync_found = 1; step_n(1); sync_found = 0;
    id_ok = 1; step_n(1); id_ok = 0;
    step_n(2);
    crc_err = 1; step_n(1); crc_err = 0;
    load_done = 1; sync_found = 1; id_ok = 1; step_n(4);
    load_done = 0; sync_found = 0; id_ok = 0;
    pt(init_drive_low & !done_rel, 1, "R8 error state sticky");
    prog_n = 0; step_n(G + 1); prog_n = 1;
    bring_up(2'b11, 1'b1, 2);
    sync_found = 1; id_ok = 1; step_n(3); sync_found = 0; id_ok = 0;
    load_done = 1; step_n(1); load_done = 0;
    step_n(5);
    power_good = 0; step_n(3);
    pt(gwe, 0, "R1 power loss resets");
    power_good = 1; step_n(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule